// File: doc/BRIEF.md
# I2C Slave Byte Engine with Clock-Stretch Holds

This block is a 7-bit addressed I2C slave that runs from a fast system clock and oversamples the SCL and SDA lines. Both lines are open drain: the block only ever pulls a line low, through a drive-low enable per line. Bytes the master writes, including the matching address byte, land in a single receive buffer. A buffer-full flag and an overflow flag guard that buffer. For a read address the block shifts out a byte that software has preloaded, and repeats it for as long as the master acknowledges.

Software sets the options through a four-register control port. It can stretch the clock after a matching address byte, after a data byte, or both. While the clock is stretched, software reads the byte and chooses ACK or NACK before it releases SCL. Other options choose whether the overflow flag blocks buffer updates, turn on a bus-collision check while the slave transmits, and enable start and stop interrupt flags. A further bit sets a longer SDA hold time after each falling SCL edge.

Register map (2-bit address): 0 = read receive buffer / write transmit byte; 1 = status; 2 = control; 3 = own address (bits 6:0) plus hold-time select (bit 7).

Top module: `i2c_slave_hold`

## Requirements
- R1: After reset, status (register 1) reads 0x00, control (register 2) reads 0x80, and both drive-low enables are 0.
- R2: A byte whose upper seven bits equal the own address is ACKed in the 9th clock (SDA pulled low) and stored in the buffer. Any other address is not ACKed and leaves full (status bit 0) at 0.
- R3: With address hold (control bit 0) set, SCL is pulled low after the 8th falling edge of a matching address. Control bit 7 then reads 0. SCL stays low until software writes control with bit 7 = 1. The ACK level then comes from control bit 6 (0 = ACK, 1 = NACK).
- R4: With data hold (control bit 1) set, the same hold and software ACK choice apply after the 8th falling edge of each received data byte. No hold is applied to the address byte.
- R5: The acknowledge-window flag (status bit 5) sets on the 8th falling SCL edge and clears on the 9th rising edge. It only sets while a hold enable is on; otherwise it stays 0.
- R6: With overwrite (control bit 2) clear, a byte arriving while full is set sets overflow (status bit 1), is NACKed and leaves the buffer unchanged. While overflow is set, no byte is stored or ACKed.
- R7: With overwrite set, a byte is stored and ACKed whenever full is 0, regardless of overflow.
- R8: With collision detect (control bit 3) set, SDA sampled low on a rising SCL edge during a transmitted bit that the slave leaves high sets status bit 4. The slave then goes idle and drives nothing more.
- R9: A start or repeated start sets status bit 2 when control bit 4 is set. A stop sets status bit 3 when control bit 5 is set. A disabled event leaves its flag at 0.
- R10: SDA changes no sooner than 100 ns after a falling SCL edge. With register 3 bit 7 set, the minimum is 300 ns. Both are counted in system clocks from CLK_HZ.
- R11: Reading register 0 clears full. Writing 0 to status bits 1 to 4 clears them.
- R12: After a matching address with the read bit (bit 0 = 1), the slave sends register 0's written byte MSB first. It repeats the byte on a master ACK and goes idle with SDA released on a master NACK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |

## Verification
The bench aims at the two buffer policies with overflow already set. A design that kept gating on overflow in overwrite mode would NACK the byte that should be stored. One that ignored the flag in normal mode would overwrite a byte that software has not read. Both hold modes are released through software with a chosen ACK level. A release that let SDA move after SCL rose would show up as a spurious start or stop, and a wrong ACK source would invert the answer the master sees. The bench measures the SDA delay after SCL falls for both hold-time settings. It also forces a collision in the first transmitted bit and checks the next bit: a slave that kept transmitting would pull SDA low where the master expects it released.

// File: rtl/i2c_slave_hold.sv
module i2c_slave_hold #(
  parameter int CLK_HZ = 250_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam int HOLD_S = CLK_HZ / 10_000_000 + 1;
  localparam int HOLD_L = 3 * (CLK_HZ / 10_000_000) + 1;
  localparam int HW = $clog2(HOLD_L + 1);

  typedef enum logic [1:0] {IDLE, ADDR, RX, TX} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_ev = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

  st_t st;
  logic [3:0] cnt;
  logic [7:0] sh, rxbuf, txbuf;
  logic [6:0] own;
  logic hold300, rw, mack, drv_want, scl_hold, rel_req;
  logic full, ovf, start_if, stop_if, coll_if, acktim;
  logic ahen, dhen, ovren, collen, sie, pie, nack;
  logic [HW-1:0] hcnt;

  wire match  = sh[7:1] == own;
  wire accept = !full && (ovren || !ovf);
  wire in_rx  = (st == ADDR) || (st == RX);

  assign scl_oe = scl_hold;

  always_comb begin
    case (reg_addr)
      2'd0: reg_rdata = rxbuf;
      2'd1: reg_rdata = {2'b00, acktim, coll_if, stop_if, start_if, ovf, full};
      2'd2: reg_rdata = {~scl_hold, nack, pie, sie, collen, ovren, dhen, ahen};
      default: reg_rdata = {hold300, own};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      st <= IDLE; cnt <= '0; sh <= '0; rxbuf <= '0; txbuf <= '0; own <= '0;
      hold300 <= 1'b0; rw <= 1'b0; mack <= 1'b0; drv_want <= 1'b0;
      scl_hold <= 1'b0; rel_req <= 1'b0; sda_oe <= 1'b0; hcnt <= '0;
      full <= 1'b0; ovf <= 1'b0; start_if <= 1'b0; stop_if <= 1'b0;
      coll_if <= 1'b0; acktim <= 1'b0;
      ahen <= 1'b0; dhen <= 1'b0; ovren <= 1'b0; collen <= 1'b0;
      sie <= 1'b0; pie <= 1'b0; nack <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;

      if (scl_fall) hcnt <= hold300 ? HW'(HOLD_L - 1) : HW'(HOLD_S - 1);
      else if (hcnt != '0) hcnt <= hcnt - 1'b1;
      if (hcnt == '0 && !scl_fall) sda_oe <= drv_want;

      if (rel_req && sda_oe == drv_want) begin
        scl_hold <= 1'b0;
        rel_req  <= 1'b0;
      end
      if (scl_hold) drv_want <= ~nack;

      if (reg_re && reg_addr == 2'd0) full <= 1'b0;

      if (reg_we) begin
        case (reg_addr)
          2'd0: txbuf <= reg_wdata;
          2'd1: begin
            ovf      <= ovf & reg_wdata[1];
            start_if <= start_if & reg_wdata[2];
            stop_if  <= stop_if & reg_wdata[3];
            coll_if  <= coll_if & reg_wdata[4];
          end
          2'd2: begin
            {nack, pie, sie, collen, ovren, dhen, ahen} <= reg_wdata[6:0];
            if (scl_hold) begin
              drv_want <= ~reg_wdata[6];
              if (reg_wdata[7]) rel_req <= 1'b1;
            end
          end
          default: {hold300, own} <= reg_wdata;
        endcase
      end

      if (start_ev || stop_ev) begin
        st <= start_ev ? ADDR : IDLE;
        cnt <= '0;
        scl_hold <= 1'b0;
        rel_req <= 1'b0;
        drv_want <= 1'b0;
        acktim <= 1'b0;
        if (start_ev && sie) start_if <= 1'b1;
        if (stop_ev && pie) stop_if <= 1'b1;
      end else if (scl_rise && st != IDLE) begin
        cnt <= cnt + 4'd1;
        if (in_rx && cnt < 4'd8) sh <= {sh[6:0], sda_s};
        if (in_rx && cnt == 4'd8) acktim <= 1'b0;
        if (st == TX && cnt < 4'd8 && collen && !sda_oe && !sda_s) begin
          coll_if  <= 1'b1;
          st       <= IDLE;
          drv_want <= 1'b0;
        end
        if (st == TX && cnt == 4'd8) mack <= ~sda_s;
      end else if (scl_fall && in_rx && cnt == 4'd8) begin
        if (st == ADDR && !match) begin
          st <= IDLE;
        end else begin
          if (accept) begin
            rxbuf <= sh;
            full  <= 1'b1;
          end else if (full) begin
            ovf <= 1'b1;
          end
          drv_want <= accept;
          if (st == ADDR) rw <= sh[0];
          if ((st == ADDR && ahen) || (st == RX && dhen)) scl_hold <= 1'b1;
          if (ahen || dhen) acktim <= 1'b1;
        end
      end else if (scl_fall && in_rx && cnt == 4'd9) begin
        cnt <= '0;
        if (!drv_want) begin
          st <= IDLE;
        end else if (st == ADDR && rw) begin
          st <= TX;
          sh <= txbuf;
          drv_want <= ~txbuf[7];
        end else begin
          st <= RX;
          drv_want <= 1'b0;
        end
      end else if (scl_fall && st == TX) begin
        if (cnt >= 4'd1 && cnt <= 4'd7) begin
          sh <= {sh[6:0], 1'b0};
          drv_want <= ~sh[6];
        end else if (cnt == 4'd8) begin
          drv_want <= 1'b0;
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          if (mack) begin
            sh <= txbuf;
            drv_want <= ~txbuf[7];
          end else begin
            st <= IDLE;
            drv_want <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_slave_hold_chk.sv
module i2c_slave_hold_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       full,
  input logic       ovf,
  input logic       coll_if,
  input logic       idle,
  input logic [7:0] rxbuf
);
  AST_HOLD_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !scl_s); // R3
  AST_RELEASE_SDA_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> $stable(sda_oe)); // R3
  AST_OVF_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $stable(rxbuf)); // R6
  AST_STORE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rxbuf) |-> full); // R7
  AST_COLL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_if) |-> idle); // R8
endmodule

bind i2c_slave_hold i2c_slave_hold_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .full(full), .ovf(ovf), .coll_if(coll_if), .idle(st == IDLE), .rxbuf(rxbuf)
);

// File: tb/sim_i2c_slave_hold.sv
`timescale 1ns/1ps
module sim_i2c_slave_hold;
  localparam int Q = 100;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_oe, sda_oe;
  wire scl_line = scl_m & ~scl_oe;
  wire sda_line = sda_m & ~sda_oe;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  i2c_slave_hold u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_tests++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic m_start();
    sda_m = 1'b1; gap(Q); scl_m = 1'b1; gap(Q); sda_m = 1'b0; gap(Q); scl_m = 1'b0; gap(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; gap(Q); scl_m = 1'b1; gap(Q); sda_m = 1'b1; gap(Q);
  endtask

  task automatic clock_bit(input logic b, output logic r);
    sda_m = b; gap(Q); scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    gap(Q); r = sda_line; scl_m = 1'b0; gap(Q);
  endtask

  task automatic send8(input logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    send8(b); clock_bit(1'b1, r); ack = !r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, r); v[i] = r; end
    clock_bit(!mack, r);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd1, d); chk("R1 status", d, 8'h00);
    rd(2'd2, d); chk("R1 control", d, 8'h80);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
  endtask

  task automatic t_write();
    logic ack; logic [7:0] d;
    m_start(); send8(8'h54);
    rd(2'd1, d); chk("R5 no window without hold", d[5], 0);
    clock_bit(1'b1, ack); chk("R2 address ACK", !ack, 1);
    rd(2'd0, d); chk("R2 address stored", d, 8'h54);
    rd(2'd1, d); chk("R11 read clears full", d[0], 0);
    wr_byte(8'h5C, ack); chk("R2 data ACK", ack, 1);
    rd(2'd0, d); chk("R2 data stored", d, 8'h5C);
    m_stop();
    rd(2'd1, d); chk("R9 disabled flags stay 0", d, 8'h00);
  endtask

  task automatic t_mismatch();
    logic ack; logic [7:0] d;
    m_start(); wr_byte(8'h44, ack); chk("R2 mismatch NACK", ack, 0);
    rd(2'd1, d); chk("R2 mismatch not stored", d[0], 0);
    m_stop();
  endtask

  task automatic make_ovf();
    logic ack; logic [7:0] d;
    m_start(); wr_byte(8'h54, ack); wr_byte(8'h11, ack);
    chk("R6 byte while full NACK", ack, 0);
    m_stop();
    rd(2'd1, d); chk("R6 overflow set", d[1:0], 2'b11);
    rd(2'd0, d); chk("R6 buffer kept", d, 8'h54);
  endtask

  task automatic t_overflow();
    logic ack; logic [7:0] d;
    make_ovf();
    m_start(); wr_byte(8'h54, ack); chk("R6 blocked while overflow", ack, 0);
    m_stop();
    rd(2'd1, d); chk("R6 nothing stored", d, 8'h02);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R11 overflow cleared", d, 8'h00);
  endtask

  task automatic t_overwrite();
    logic ack; logic [7:0] d;
    make_ovf();
    wr(2'd2, 8'h04);
    m_start(); wr_byte(8'h54, ack); chk("R7 ACK despite overflow", ack, 1);
    rd(2'd0, d); chk("R7 address stored", d, 8'h54);
    wr_byte(8'h77, ack); chk("R7 data ACK", ack, 1);
    rd(2'd0, d); chk("R7 data stored", d, 8'h77);
    m_stop();
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_ahold();
    logic r, ack; logic [7:0] d;
    wr(2'd2, 8'h01);
    m_start(); send8(8'h54); gap(10);
    chk("R3 SCL held", scl_oe, 1);
    rd(2'd1, d); chk("R5 window set", d[5], 1);
    rd(2'd2, d); chk("R3 release bit reads 0", d[7], 0);
    fork
      clock_bit(1'b1, r);
      begin gap(60); chk("R3 still held", scl_line, 0); wr(2'd2, 8'h81); end
    join
    chk("R3 software ACK", r, 0);
    rd(2'd1, d); chk("R5 window cleared", d[5], 0);
    rd(2'd0, d);
    wr_byte(8'h3C, ack); chk("R3 data not held", ack, 1);
    m_stop();
    rd(2'd0, d); chk("R3 data stored", d, 8'h3C);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_dhold();
    logic r, ack; logic [7:0] d;
    wr(2'd2, 8'h02);
    m_start(); wr_byte(8'h54, ack); chk("R4 address not held", ack, 1);
    rd(2'd0, d);
    send8(8'h9E); gap(10);
    chk("R4 SCL held", scl_oe, 1);
    rd(2'd1, d); chk("R5 window on data", d[5], 1);
    fork
      clock_bit(1'b1, r);
      begin gap(60); wr(2'd2, 8'hC2); end
    join
    chk("R4 software NACK", r, 1);
    m_stop();
    rd(2'd0, d); chk("R4 data stored", d, 8'h9E);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_irq();
    logic ack; logic [7:0] d;
    wr(2'd2, 8'h10);
    m_start(); rd(2'd1, d); chk("R9 start flag", d, 8'h04);
    m_stop();  rd(2'd1, d); chk("R9 stop disabled", d, 8'h04);
    wr(2'd1, 8'h00); wr(2'd2, 8'h20);
    m_start(); rd(2'd1, d); chk("R9 start disabled", d, 8'h00);
    m_stop();  rd(2'd1, d); chk("R9 stop flag", d, 8'h08);
    wr(2'd1, 8'h00); wr(2'd2, 8'h10);
    m_start(); wr_byte(8'h54, ack); rd(2'd0, d); wr(2'd1, 8'h00);
    m_start(); rd(2'd1, d); chk("R9 repeated start flag", d[2], 1);
    m_stop();
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic meas(output int dly);
    logic r; logic [7:0] d;
    m_start();
    for (int i = 7; i >= 1; i--) clock_bit(((8'h54 >> i) & 1) != 0, r);
    sda_m = 1'b0; gap(Q); scl_m = 1'b1; gap(Q); scl_m = 1'b0;
    dly = 0;
    while (!sda_oe && dly < 300) begin @(negedge clk); dly++; end
    gap(Q);
    clock_bit(1'b1, r);
    m_stop();
    rd(2'd0, d);
  endtask

  task automatic t_holdtime();
    int dly;
    meas(dly); chk_rng("R10 short hold cycles", dly, 25, 40);
    wr(2'd3, 8'hAA);
    meas(dly); chk_rng("R10 long hold cycles", dly, 75, 90);
    wr(2'd3, 8'h2A);
  endtask

  task automatic t_collision();
    logic r, ack; logic [7:0] d;
    wr(2'd0, 8'hBF); wr(2'd2, 8'h08);
    m_start(); wr_byte(8'h55, ack); rd(2'd0, d);
    clock_bit(1'b0, r);
    rd(2'd1, d); chk("R8 collision flag", d[4], 1);
    clock_bit(1'b1, r); chk("R8 slave idle after collision", r, 1);
    m_stop();
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_transmit();
    logic ack; logic [7:0] d, v;
    wr(2'd0, 8'hA5);
    m_start(); wr_byte(8'h55, ack); chk("R12 read address ACK", ack, 1);
    rd(2'd0, d); chk("R2 read address stored", d, 8'h55);
    rd_byte(1'b1, v); chk("R12 first byte", v, 8'hA5);
    rd_byte(1'b0, v); chk("R12 repeated byte", v, 8'hA5);
    chk("R12 SDA released after NACK", sda_oe, 0);
    m_stop();
  endtask

  initial begin
    gap(5); rst_n = 1'b1; gap(5);
    t_reset();
    wr(2'd3, 8'h2A);
    t_write();
    t_mismatch();
    t_overflow();
    t_overwrite();
    t_ahold();
    t_dhold();
    t_irq();
    t_holdtime();
    t_collision();
    t_transmit();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule